// File: doc/BRIEF.md
# Plane-Run Coincidence Final Trigger

This block forms the final trigger for a layered tracking detector built as a stack of planes with two orthogonal readout views, X and Y. Each plane reports four fold flags, 1-fold to 4-fold, that describe how many neighbouring pickup groups fired together. Software picks a fold pair M x N. A view then triggers when the M-fold flag is set in N adjacent planes of that view. The final trigger is the OR of the X and Y view triggers.

A small address/data register bus gives the host control over several things: the fold selection, a per-plane enable for each view, and an enable for each trigger output. When a final trigger is accepted, the block does three things. It raises an interrupt request, it captures every raw fold flag into a snapshot for later readout, and it refuses further final triggers until the host clears the request. Saturating scalers count the X, Y and accepted final triggers.

Top module: `mxn_final_trigger`

## Requirements
- R1: Bit 4p+k of `x_fold_i` (or `y_fold_i`) is the (k+1)-fold flag of plane p of that view. The control register at address 0 holds M-1 in bits [1:0] and N-1 in bits [4:2], and the view logic uses flag k = M-1 of each plane.
- R2: `x_trig_o` is high, in the same cycle as the inputs, when the selected flag is set in at least N planes p..p+N-1 that are adjacent and enabled. Runs do not wrap from the last plane back to plane 0. `y_trig_o` is formed in the same way from the Y inputs.
- R3: The plane enable registers sit at address 1 (X) and address 2 (Y). Bit p = 1 enables plane p. The flags of a disabled plane count as false in the run search.
- R4: Control bit 5 gates `x_trig_o` and bit 6 gates `y_trig_o`. `final_trig_o` equals (`x_trig_o` | `y_trig_o`) AND control bit 7.
- R5: On a clock edge where `final_trig_o` is high and `irq_o` is low, `irq_o` is set. While `irq_o` is set, no final trigger is accepted. `irq_o` clears only when the host writes address 3 with bit 0 set. A final trigger still held at that point is accepted on the next edge.
- R6: An accepted final trigger latches the raw inputs {`y_fold_i`, `x_fold_i`}, ignoring the plane enables, into a snapshot. The snapshot is zero-padded above bit 8*PLANES-1. Word i (bits 32i+31..32i) reads at address 8+i. The snapshot does not change until the next acceptance.
- R7: Scalers sit at address 4 (X), address 5 (Y) and address 6 (final). The X and Y scalers count rising edges of `x_trig_o` and `y_trig_o`. The final scaler counts accepted final triggers. Each scaler is CNT_W bits wide (default 24) and stops at all ones.
- R8: Writing address 3 with bit 1 set clears all three scalers. A clear beats a count that falls in the same cycle.
- R9: After reset, `irq_o`, the scalers and the snapshot are 0. The control register is 0xED (2x4, all outputs enabled), and both plane enable registers are all ones. Reading address 3 returns `irq_o` in bit 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_fold_i | input | 4*PLANES | X view fold flags, four per plane |
| y_fold_i | input | 4*PLANES | Y view fold flags, four per plane |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Register write data |
| bus_rdata_o | output | DW | Register read data (combinational) |
| x_trig_o | output | 1 | Gated X view M x N trigger |
| y_trig_o | output | 1 | Gated Y view M x N trigger |
| final_trig_o | output | 1 | Gated final trigger |
| irq_o | output | 1 | Host interrupt request |

## Verification
There are two same-cycle collisions to check, each provoked on purpose by the bench.

The first is a host command meeting a trigger event in the same cycle. The bench raises an X run in the same cycle as a scaler-clear write. It expects the X and final scalers to read 0 afterwards, while the interrupt is still taken.

The second is an interrupt clear written while a final trigger is held high. The bench expects `irq_o` to read low for exactly one cycle and then rise again. At that point the final scaler has advanced by one and the snapshot holds the new inputs.

// File: rtl/mxn_trig_pkg.sv
package mxn_trig_pkg;

   localparam int FOLDS = 4;

   // control register layout: behaviour depends on field positions
   typedef struct packed {
      logic       en_final;   // bit 7
      logic       en_y;       // bit 6
      logic       en_x;       // bit 5
      logic [2:0] n_m1;       // bits 4:2
      logic [1:0] m_m1;       // bits 1:0
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{en_final: 1'b1, en_y: 1'b1, en_x: 1'b1,
                                  n_m1: 3'd3, m_m1: 2'd1};

   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_XEN   = 4'd1;
   localparam logic [3:0] A_YEN   = 4'd2;
   localparam logic [3:0] A_CMD   = 4'd3;
   localparam logic [3:0] A_CNTX  = 4'd4;
   localparam logic [3:0] A_CNTY  = 4'd5;
   localparam logic [3:0] A_CNTF  = 4'd6;
   localparam logic [3:0] A_SNAP  = 4'd8;

endpackage

// File: rtl/fold_run_detect.sv
module fold_run_detect
   import mxn_trig_pkg::*;
#(
   parameter int PLANES = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [FOLDS*PLANES-1:0]   folds_i,
   input  logic [PLANES-1:0]         plane_en_i,
   input  logic [1:0]                m_m1_i,
   input  logic [2:0]                n_m1_i,
   output logic                      hit_o
);

   localparam int RUN_W = 4;

   logic [PLANES-1:0] sel;
   logic [RUN_W-1:0]  run;

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_plane
         logic [FOLDS-1:0] pf;
         assign pf     = folds_i[FOLDS*p +: FOLDS];
         assign sel[p] = pf[m_m1_i] & plane_en_i[p];
      end
   endgenerate

   // length of the adjacent run ending at each plane; no wrap-around
   always_comb begin
      run   = '0;
      hit_o = 1'b0;
      for (int p = 0; p < PLANES; p++) begin
         if (sel[p])
            run = (run == {RUN_W{1'b1}}) ? run : run + 1'b1;
         else
            run = '0;
         if (run > {1'b0, n_m1_i})
            hit_o = 1'b1;
      end
   end

   // R2: a hit needs at least N selected planes
   a_r2_hit_needs_n: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ($countones(sel) > int'(n_m1_i)));

endmodule

// File: rtl/sat_scaler.sv
module sat_scaler #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (inc_i && cnt_o != TOP)
         cnt_o <= cnt_o + 1'b1;
   end

   a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == TOP && !clr_i) |=> (cnt_o == TOP));

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/mxn_final_trigger.sv
module mxn_final_trigger
   import mxn_trig_pkg::*;
#(
   parameter int PLANES = 14,
   parameter int DW     = 32,
   parameter int AW     = 4,
   parameter int CNT_W  = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FOLDS*PLANES-1:0]  x_fold_i,
   input  logic [FOLDS*PLANES-1:0]  y_fold_i,
   input  logic                     bus_wr_i,
   input  logic [AW-1:0]            bus_addr_i,
   input  logic [DW-1:0]            bus_wdata_i,
   output logic [DW-1:0]            bus_rdata_o,
   output logic                     x_trig_o,
   output logic                     y_trig_o,
   output logic                     final_trig_o,
   output logic                     irq_o
);

   localparam int VIEW_BITS  = FOLDS * PLANES;
   localparam int RAW_BITS   = 2 * VIEW_BITS;
   localparam int SNAP_WORDS = (RAW_BITS + DW - 1) / DW;
   localparam int SNAP_BITS  = SNAP_WORDS * DW;
   localparam int N_SCALERS  = 3;

   generate
      if (PLANES < 2 || PLANES > DW) begin : g_bad_planes
         $error("PLANES must lie in 2..DW");
      end
      if (DW < 8 || CNT_W > DW || CNT_W < 1) begin : g_bad_widths
         $error("DW must be >= 8 and CNT_W in 1..DW");
      end
      if (AW < 4 || (int'(A_SNAP) + SNAP_WORDS) > (1 << AW)) begin : g_bad_map
         $error("address space too small for the snapshot words");
      end
   endgenerate

   ctrl_t                  ctrl_q;
   logic [PLANES-1:0]      xen_q, yen_q;
   logic                   irq_q;
   logic [SNAP_BITS-1:0]   snap_q, snap_in;
   logic                   prev_x_q, prev_y_q;
   logic                   cmd_wr, clr_irq, clr_cnt, accept;

   logic [VIEW_BITS-1:0]   view_fold [2];
   logic [PLANES-1:0]      view_en   [2];
   logic [1:0]             view_hit;
   logic [N_SCALERS-1:0]   sc_inc;
   logic [CNT_W-1:0]       sc_cnt    [N_SCALERS];

   assign view_fold[0] = x_fold_i;
   assign view_fold[1] = y_fold_i;
   assign view_en[0]   = xen_q;
   assign view_en[1]   = yen_q;

   generate
      for (genvar v = 0; v < 2; v++) begin : g_view
         fold_run_detect #(.PLANES(PLANES)) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .folds_i    (view_fold[v]),
            .plane_en_i (view_en[v]),
            .m_m1_i     (ctrl_q.m_m1),
            .n_m1_i     (ctrl_q.n_m1),
            .hit_o      (view_hit[v])
         );
      end
   endgenerate

   assign x_trig_o     = view_hit[0] & ctrl_q.en_x;
   assign y_trig_o     = view_hit[1] & ctrl_q.en_y;
   assign final_trig_o = (x_trig_o | y_trig_o) & ctrl_q.en_final;

   assign cmd_wr  = bus_wr_i && (bus_addr_i == AW'(A_CMD));
   assign clr_irq = cmd_wr & bus_wdata_i[0];
   assign clr_cnt = cmd_wr & bus_wdata_i[1];
   assign accept  = final_trig_o & ~irq_q;
   assign irq_o   = irq_q;

   always_comb begin
      snap_in               = '0;
      snap_in[RAW_BITS-1:0] = {y_fold_i, x_fold_i};
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         xen_q  <= '1;
         yen_q  <= '1;
      end else if (bus_wr_i) begin
         if (bus_addr_i == AW'(A_CTRL)) ctrl_q <= ctrl_t'(bus_wdata_i[7:0]);
         if (bus_addr_i == AW'(A_XEN))  xen_q  <= bus_wdata_i[PLANES-1:0];
         if (bus_addr_i == AW'(A_YEN))  yen_q  <= bus_wdata_i[PLANES-1:0];
      end
   end

   // interrupt, snapshot and edge history
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         snap_q   <= '0;
         prev_x_q <= 1'b0;
         prev_y_q <= 1'b0;
      end else begin
         prev_x_q <= x_trig_o;
         prev_y_q <= y_trig_o;
         if (accept) begin
            irq_q  <= 1'b1;
            snap_q <= snap_in;
         end else if (clr_irq) begin
            irq_q  <= 1'b0;
         end
      end
   end

   assign sc_inc[0] = x_trig_o & ~prev_x_q;
   assign sc_inc[1] = y_trig_o & ~prev_y_q;
   assign sc_inc[2] = accept;

   generate
      for (genvar s = 0; s < N_SCALERS; s++) begin : g_scaler
         sat_scaler #(.W(CNT_W)) u_sc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_cnt),
            .inc_i (sc_inc[s]),
            .cnt_o (sc_cnt[s])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      unique case (bus_addr_i)
         AW'(A_CTRL): bus_rdata_o[7:0]        = ctrl_q;
         AW'(A_XEN):  bus_rdata_o[PLANES-1:0] = xen_q;
         AW'(A_YEN):  bus_rdata_o[PLANES-1:0] = yen_q;
         AW'(A_CMD):  bus_rdata_o[0]          = irq_q;
         AW'(A_CNTX): bus_rdata_o[CNT_W-1:0]  = sc_cnt[0];
         AW'(A_CNTY): bus_rdata_o[CNT_W-1:0]  = sc_cnt[1];
         AW'(A_CNTF): bus_rdata_o[CNT_W-1:0]  = sc_cnt[2];
         default: begin
            for (int w = 0; w < SNAP_WORDS; w++)
               if (bus_addr_i == AW'(int'(A_SNAP) + w))
                  bus_rdata_o = snap_q[w*DW +: DW];
         end
      endcase
   end

   a_r5_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (final_trig_o && !irq_o) |=> irq_o);

   a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_irq) |=> irq_o);

   a_r6_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> $stable(snap_q));

   a_r4_final_gated: assert property (@(posedge clk) disable iff (!rst_n)
      final_trig_o |-> (x_trig_o || y_trig_o));

endmodule

// File: tb/mxn_final_trigger_test.sv
module mxn_final_trigger_test;

   localparam int PL = 14;
   localparam int VB = 4 * PL;
   localparam int CW = 4;

   typedef struct packed {
      logic [2:0]  m;
      logic [3:0]  n;
      logic [1:0]  fold;
      logic [13:0] xp;
      logic [13:0] yp;
      logic        ex;
      logic        ey;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 4'd5, 2'd0, 14'h001F, 14'h0000, 1'b1, 1'b0},
      '{3'd1, 4'd5, 2'd0, 14'h000F, 14'h3E00, 1'b0, 1'b1},
      '{3'd2, 4'd4, 2'd1, 14'h00F0, 14'h00F0, 1'b1, 1'b1},
      '{3'd2, 4'd4, 2'd0, 14'h00F0, 14'h0000, 1'b0, 1'b0},
      '{3'd3, 4'd3, 2'd2, 14'h2007, 14'h0005, 1'b1, 1'b0},
      '{3'd4, 4'd2, 2'd3, 14'h3000, 14'h2001, 1'b1, 1'b0},
      '{3'd4, 4'd2, 2'd3, 14'h1555, 14'h0180, 1'b0, 1'b1},
      '{3'd3, 4'd3, 2'd2, 14'h0000, 14'h3FFF, 1'b0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VB-1:0] x_fold = '0, y_fold = '0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          x_trig, y_trig, final_trig, irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [127:0] exp_snap;

   always #10 clk = ~clk;

   mxn_final_trigger #(.PLANES(PL), .DW(32), .AW(4), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .x_fold_i(x_fold), .y_fold_i(y_fold),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .x_trig_o(x_trig), .y_trig_o(y_trig),
      .final_trig_o(final_trig), .irq_o(irq));

   function automatic logic [VB-1:0] fv(input logic [13:0] planes, input logic [1:0] f);
      logic [VB-1:0] v = '0;
      for (int p = 0; p < PL; p++) if (planes[p]) v[4*p + int'(f)] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic ctrl(input int m, input int n, input logic [2:0] en);
      wr(4'd0, {24'd0, en, 3'(n - 1), 2'(m - 1)});
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [VB-1:0] xa, yb;
      xa = fv(14'h001F, 2'd0);
      yb = fv(14'h3E00, 2'd0);

      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check("R9 irq", {31'd0, irq}, 32'd0);
      rd(4'd0, d); check("R9 ctrl", d, 32'h0000_00ED);
      rd(4'd1, d); check("R9 xen", d, 32'h0000_3FFF);
      rd(4'd2, d); check("R9 yen", d, 32'h0000_3FFF);
      rd(4'd6, d); check("R9 cntf", d, 32'd0);
      rd(4'd8, d); check("R9 snap", d, 32'd0);
      rd(4'd7, d); check("R9 unmapped", d, 32'd0);

      // R1 R2 table of fold pairs and run patterns
      for (int i = 0; i < NV; i++) begin
         ctrl(int'(VEC[i].m), int'(VEC[i].n), 3'b111);
         x_fold = fv(VEC[i].xp, VEC[i].fold);
         y_fold = fv(VEC[i].yp, VEC[i].fold);
         #1;
         check($sformatf("R2 x vec%0d", i), {31'd0, x_trig}, {31'd0, VEC[i].ex});
         check($sformatf("R2 y vec%0d", i), {31'd0, y_trig}, {31'd0, VEC[i].ey});
         check($sformatf("R4 final vec%0d", i), {31'd0, final_trig},
               {31'd0, VEC[i].ex | VEC[i].ey});
         x_fold = '0; y_fold = '0;
         @(negedge clk);
         wr(4'd3, 32'h3);
      end

      // R3 plane enable: plane 2 disabled breaks a 5-run
      ctrl(1, 5, 3'b111);
      wr(4'd1, 32'h3FFB);
      x_fold = xa; #1;
      check("R3 disabled plane", {31'd0, x_trig}, 32'd0);
      x_fold = '0;
      wr(4'd1, 32'h3FFF);
      x_fold = xa; #1;
      check("R3 re-enabled", {31'd0, x_trig}, 32'd1);
      x_fold = '0;
      @(negedge clk);
      wr(4'd3, 32'h3);

      // R4 output gating
      ctrl(1, 5, 3'b110);
      x_fold = xa; #1;
      check("R4 x gated", {30'd0, x_trig, final_trig}, 32'd0);
      y_fold = yb; #1;
      check("R4 y passes", {30'd0, y_trig, final_trig}, 32'd3);
      x_fold = '0; y_fold = '0;
      ctrl(1, 5, 3'b011);
      y_fold = yb;
      @(negedge clk);
      check("R4 final gated no irq", {30'd0, final_trig, irq}, 32'd0);
      y_fold = '0;
      ctrl(1, 5, 3'b111);
      wr(4'd3, 32'h3);

      // R5 R6 R7 interrupt, snapshot, blocking
      x_fold = xa;
      exp_snap = {16'd0, y_fold, xa};
      @(negedge clk);
      check("R5 irq set", {31'd0, irq}, 32'd1);
      rd(4'd6, d); check("R7 cntf one", d, 32'd1);
      rd(4'd4, d); check("R7 cntx one", d, 32'd1);
      rd(4'd8, d); check("R6 snap w0", d, exp_snap[31:0]);
      rd(4'd9, d); check("R6 snap w1", d, exp_snap[63:32]);
      x_fold = '0; y_fold = yb;
      @(negedge clk);
      check("R5 irq held", {31'd0, irq}, 32'd1);
      rd(4'd6, d); check("R5 blocked cntf", d, 32'd1);
      rd(4'd5, d); check("R7 cnty one", d, 32'd1);
      rd(4'd10, d); check("R6 snap held w2", d, exp_snap[95:64]);
      rd(4'd11, d); check("R6 snap held w3", d, exp_snap[127:96]);
      rd(4'd3, d); check("R9 irq readback", d, 32'd1);
      // clear while final held high
      wr(4'd3, 32'h1);
      check("R5 irq cleared", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R5 irq re-taken", {31'd0, irq}, 32'd1);
      rd(4'd6, d); check("R5 cntf two", d, 32'd2);
      exp_snap = {16'd0, yb, {VB{1'b0}}};
      rd(4'd10, d); check("R6 snap new w2", d, exp_snap[95:64]);
      rd(4'd11, d); check("R6 snap new w3", d, exp_snap[127:96]);
      y_fold = '0;
      @(negedge clk);
      wr(4'd3, 32'h3);

      // R8 scaler clear coinciding with a trigger edge
      x_fold = xa;
      wr(4'd3, 32'h2);
      rd(4'd4, d); check("R8 cntx cleared", d, 32'd0);
      rd(4'd6, d); check("R8 cntf cleared", d, 32'd0);
      check("R8 irq still taken", {31'd0, irq}, 32'd1);
      x_fold = '0;
      @(negedge clk);
      x_fold = xa;
      @(negedge clk);
      rd(4'd4, d); check("R8 count after clear", d, 32'd1);

      // R7 saturation
      x_fold = '0;
      wr(4'd3, 32'h3);
      for (int k = 0; k < 20; k++) begin
         x_fold = xa; @(negedge clk);
         x_fold = '0; @(negedge clk);
      end
      rd(4'd4, d); check("R7 saturate", d, 32'd15);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule